// File: doc/BRIEF.md
# Interrupting General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port for a larger SoC. Software reaches it through a plain register interface: a write strobe, a byte address, write data, and read data that is registered one cycle after the address is presented. Each pin drives its output value when its direction bit is 1. Every pin is also sampled through a two-stage synchronizer, and the synchronized level is what software reads back.

Every pin can raise an interrupt. A 2-bit trigger field picks low level, high level, rising edge or falling edge as the condition. Fields for pins 0 to 15 live in one configuration word and fields for pins 16 to 31 live in the next one. A detected condition latches a per-pin status bit. Software clears a status bit by writing a 1 to it. A separate mask word decides which latched bits drive the single combined interrupt line. Clearing a mask bit therefore hides a pin without losing its event.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the direction, data, both configuration, mask and status registers are all zero, and `pin_oe`, `pin_out` and `irq` are low.
- R2: Writing word offset 0x04 sets the direction register. Bit p of `pin_oe` follows it, where 1 means output and 0 means input. The register reads back at 0x04.
- R3: Writing offset 0x00 sets the value on `pin_out`. Reading offset 0x00 returns `pin_in` after two synchronizing flops.
- R4: A pin's trigger field is 2 bits wide and starts at bit 2*(p mod 16). It lives at offset 0x08 for pins 0-15 and at 0x0C for pins 16-31. The encoding is 00 low level, 01 high level, 10 rising edge and 11 falling edge. Both words read back as written.
- R5: With rising-edge trigger, a 0-to-1 change of the synchronized input sets the pin's status bit (offset 0x14). A 1-to-0 change does not set it.
- R6: With falling-edge trigger, a 1-to-0 change sets the status bit and a 0-to-1 change does not. A latched bit stays set after the input returns.
- R7: With a level trigger, the status bit is set on every cycle that the level holds. A clear written while the level holds leaves it reading 1. The bit stays latched after the level goes away.
- R8: Writing offset 0x14 clears each status bit written as 1 and leaves each bit written as 0 unchanged. Status bits never drop except by such a write.
- R9: `irq` goes high one cycle after any status bit is set whose mask bit (offset 0x10) is 1. Clearing the mask bit drops `irq` but keeps the status bit.
- R10: When an edge event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: Offsets 0x18 and 0x1C, and any address with nonzero low two bits, read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Levels driven on output pins |
| pin_oe | output | 32 | Output enable per pin, 1 means drive |
| irq | output | 1 | Combined masked interrupt request |

## Verification
Trigger detection is tried with four kinds of input pattern:
- Single-pin rising changes and falling changes are applied to pins set for the opposite edge, so a detector that fires on any transition is caught.
- Levels that persist across a clearing write separate level latching from edge latching.
- A clearing write that carries zeros for other latched bits catches a status register that clears by plain overwrite.
- A rising edge is timed so that its set pulse meets a clear of the same bit, which exposes the wrong set/clear priority.

Mask toggling with a latched bit shows that masking and acknowledging are independent.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Per-pin trigger condition, 2-bit field in the configuration words
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // Word index of each register (byte address / 4)
  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_CFG_LO = 3'd2,
    REG_CFG_HI = 3'd3,
    REG_MASK   = 3'd4,
    REG_STAT   = 3'd5
  } reg_idx_e;

endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchronizer plus one history stage for edge detection
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= async_in;
      cur    <= meta_q;
      prev   <= cur;
    end
  end

endmodule

// File: rtl/gpio_trig.sv
// Per-pin trigger evaluation; produces a one-cycle set request per pin
module gpio_trig import gpio_irq_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] cfg_lo,
  input  logic [W-1:0] cfg_hi,
  output logic [W-1:0] set
);

  localparam int FPR = W / 2;  // trigger fields held by one config word

  for (genvar p = 0; p < W; p++) begin : g_pin
    localparam int SLOT = p % FPR;
    trig_e kind;

    if (p < FPR) begin : g_lo
      assign kind = trig_e'(cfg_lo[2*SLOT +: 2]);
    end else begin : g_hi
      assign kind = trig_e'(cfg_hi[2*SLOT +: 2]);
    end

    always_comb begin
      unique case (kind)
        TRIG_LOW:  set[p] = ~cur[p];
        TRIG_HIGH: set[p] =  cur[p];
        TRIG_RISE: set[p] =  cur[p] & ~prev[p];
        TRIG_FALL: set[p] = ~cur[p] &  prev[p];
        default:   set[p] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_status.sv
// Latched event bits with write-one-to-clear; set has priority
module gpio_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] sts,
  output logic         irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      irq <= 1'b0;
    end else begin
      sts <= (sts & ~clr) | set;
      irq <= |(sts & mask);
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port import gpio_irq_pkg::*; #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);

  localparam int IDX_LSB = 2;
  localparam int IDX_W   = AW - IDX_LSB;

  logic [W-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q;
  logic [W-1:0] pin_cur, pin_prev, evt_set, sts_q, sts_clr;
  logic [IDX_W-1:0] idx;
  logic aligned;
  logic sel_data, sel_dir, sel_cfg_lo, sel_cfg_hi, sel_mask, sel_stat;

  assign idx     = bus_addr[AW-1:IDX_LSB];
  assign aligned = (bus_addr[IDX_LSB-1:0] == '0);

  assign sel_data   = bus_wr && aligned && (idx == IDX_W'(REG_DATA));
  assign sel_dir    = bus_wr && aligned && (idx == IDX_W'(REG_DIR));
  assign sel_cfg_lo = bus_wr && aligned && (idx == IDX_W'(REG_CFG_LO));
  assign sel_cfg_hi = bus_wr && aligned && (idx == IDX_W'(REG_CFG_HI));
  assign sel_mask   = bus_wr && aligned && (idx == IDX_W'(REG_MASK));
  assign sel_stat   = bus_wr && aligned && (idx == IDX_W'(REG_STAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else begin
      if (sel_data)   data_q   <= bus_wdata;
      if (sel_dir)    dir_q    <= bus_wdata;
      if (sel_cfg_lo) cfg_lo_q <= bus_wdata;
      if (sel_cfg_hi) cfg_hi_q <= bus_wdata;
      if (sel_mask)   mask_q   <= bus_wdata;
    end
  end

  assign sts_clr = sel_stat ? bus_wdata : '0;

  gpio_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .cur      (pin_cur),
    .prev     (pin_prev)
  );

  gpio_trig #(.W(W)) u_trig (
    .cur    (pin_cur),
    .prev   (pin_prev),
    .cfg_lo (cfg_lo_q),
    .cfg_hi (cfg_hi_q),
    .set    (evt_set)
  );

  gpio_status #(.W(W)) u_status (
    .clk  (clk),
    .rst  (rst),
    .set  (evt_set),
    .clr  (sts_clr),
    .mask (mask_q),
    .sts  (sts_q),
    .irq  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (!aligned) begin
      bus_rdata <= '0;
    end else begin
      case (idx)
        IDX_W'(REG_DATA):   bus_rdata <= pin_cur;
        IDX_W'(REG_DIR):    bus_rdata <= dir_q;
        IDX_W'(REG_CFG_LO): bus_rdata <= cfg_lo_q;
        IDX_W'(REG_CFG_HI): bus_rdata <= cfg_hi_q;
        IDX_W'(REG_MASK):   bus_rdata <= mask_q;
        IDX_W'(REG_STAT):   bus_rdata <= sts_q;
        default:            bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          irq,
  input logic [W-1:0]  mask,
  input logic [W-1:0]  sts,
  input logic [W-1:0]  set
);

  logic wr_dir, wr_data, wr_stat;
  assign wr_data = bus_wr && (bus_addr == AW'(5'h00));
  assign wr_dir  = bus_wr && (bus_addr == AW'(5'h04));
  assign wr_stat = bus_wr && (bus_addr == AW'(5'h14));

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq));

  assert_dir_R2: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> (pin_oe == $past(bus_wdata)));

  assert_out_R3: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> (pin_out == $past(bus_wdata)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((sts & $past(bus_wdata) & ~$past(set)) == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((sts & $past(sts)) == $past(sts)));

  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(sts & mask) != '0));

  assert_setwins_R10: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((sts & $past(set)) == $past(set)));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .mask      (mask_q),
  .sts       (sts_q),
  .set       (evt_set)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed {
    logic        rd;   // 1: read and compare, 0: write
    logic [4:0]  a;
    logic [31:0] v;    // write data or expected read data
    logic [31:0] p;    // pin_in applied first
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'h08, 32'h5555_5556, 32'h0},          // pin0 rise, others high level
    '{1'b0, 5'h0C, 32'hD555_5555, 32'h0},          // pin31 fall
    '{1'b0, 5'h14, 32'hFFFF_FFFF, 32'h0},
    '{1'b1, 5'h14, 32'h0000_0000, 32'h0},          // R8
    '{1'b1, 5'h14, 32'h0000_0001, 32'h1},          // R5
    '{1'b1, 5'h14, 32'h0000_0001, 32'h0},          // R5 fall ignored
    '{1'b0, 5'h14, 32'h0000_0001, 32'h0},
    '{1'b1, 5'h14, 32'h0000_0000, 32'h0},          // R8
    '{1'b1, 5'h14, 32'h0000_0000, 32'h8000_0000},  // R6 rise ignored
    '{1'b1, 5'h14, 32'h8000_0000, 32'h0},          // R6
    '{1'b0, 5'h14, 32'h0000_0001, 32'h0},
    '{1'b1, 5'h14, 32'h8000_0000, 32'h0},          // R8 zero bits kept
    '{1'b1, 5'h14, 32'h8000_0004, 32'h4},          // R7
    '{1'b0, 5'h14, 32'h0000_0004, 32'h4},
    '{1'b1, 5'h14, 32'h8000_0004, 32'h4},          // R7 clear while held
    '{1'b1, 5'h14, 32'h8000_0004, 32'h0},          // R7 latched
    '{1'b0, 5'h14, 32'hFFFF_FFFF, 32'h0},
    '{1'b1, 5'h14, 32'h0000_0000, 32'h0},          // R8
    '{1'b1, 5'h00, 32'h1234_0000, 32'h1234_0000}   // R3 read back
  };

  function automatic string vtag(int i);
    case (i)
      4, 5:           return "R5";
      8, 9:           return "R6";
      12, 14, 15:     return "R7";
      18:             return "R3";
      default:        return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(100_000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(5'h04, rv); chk("R1 dir", rv, 32'h0);
    rd(5'h08, rv); chk("R1 cfg_lo", rv, 32'h0);
    rd(5'h0C, rv); chk("R1 cfg_hi", rv, 32'h0);
    rd(5'h10, rv); chk("R1 mask", rv, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pin_in = VEC[i].p;
      if (!VEC[i].rd) begin
        wr(VEC[i].a, VEC[i].v);
        idle(2);
      end else begin
        idle(5);
        rd(VEC[i].a, rv);
        chk(vtag(i), rv, VEC[i].v);
      end
    end

    // R4 configuration readback
    rd(5'h08, rv); chk("R4 cfg_lo", rv, 32'h5555_5556);
    rd(5'h0C, rv); chk("R4 cfg_hi", rv, 32'hD555_5555);

    // R11 unmapped and misaligned accesses
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h11, 32'hFFFF_FFFF);
    rd(5'h18, rv); chk("R11 read 0x18", rv, 32'h0);
    rd(5'h1C, rv); chk("R11 read 0x1C", rv, 32'h0);
    rd(5'h06, rv); chk("R11 misaligned read", rv, 32'h0);
    rd(5'h10, rv); chk("R11 mask untouched", rv, 32'h0);
    rd(5'h04, rv); chk("R11 dir untouched", rv, 32'h0);

    // R2 direction
    wr(5'h04, 32'hF0F0_0F0F);
    chk("R2 pin_oe", pin_oe, 32'hF0F0_0F0F);
    rd(5'h04, rv); chk("R2 dir readback", rv, 32'hF0F0_0F0F);

    // R3 output data
    wr(5'h00, 32'h89AB_CDEF);
    chk("R3 pin_out", pin_out, 32'h89AB_CDEF);

    // R7 low level on pin1 (field 00) re-sets after clear
    @(negedge clk); pin_in = 32'h0;
    idle(4);
    wr(5'h08, 32'h5555_5552);
    wr(5'h14, 32'hFFFF_FFFF);
    idle(5);
    rd(5'h14, rv); chk("R7 low level", rv, 32'h0000_0002);
    wr(5'h08, 32'h5555_5556);
    wr(5'h14, 32'hFFFF_FFFF);
    idle(3);
    rd(5'h14, rv); chk("R8 cleared", rv, 32'h0);

    // R10 rising edge on pin0 meets a clear of bit0 in the same cycle
    @(negedge clk); pin_in = 32'h1;
    @(negedge clk);
    wr(5'h14, 32'h0000_0001);
    idle(2);
    rd(5'h14, rv); chk("R10 set wins", rv, 32'h0000_0001);

    // R9 mask gating
    chk("R9 irq masked", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h0000_0001);
    idle(1);
    chk("R9 irq unmasked", {31'h0, irq}, 32'h1);
    wr(5'h10, 32'h0);
    idle(1);
    chk("R9 irq after mask clear", {31'h0, irq}, 32'h0);
    rd(5'h14, rv); chk("R9 status kept", rv, 32'h0000_0001);
    wr(5'h10, 32'h0000_0001);
    wr(5'h14, 32'h0000_0001);
    idle(1);
    chk("R9 irq after ack", {31'h0, irq}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule